// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This controller gathers fifteen prioritised interrupt levels (1 is lowest, 15 is highest) and hands them out to between one and four processors. One pending register is shared by all processors. Each processor also has its own enable mask and its own force register. A broadcast register chooses which levels are delivered as forced interrupts to every processor, rather than being recorded as shared pending.

For each processor the block drives the number of the highest level that is both active and enabled. A processor acknowledges a level with a one-cycle strobe. The acknowledge clears that processor's forced copy of the level first, and clears the shared pending bit only when no forced copy exists.

A status register reports the processor count and one power-down flag per processor. A flag is raised through an input strobe. Writing ones to the status register clears the matching flags, which wakes those processors. All software access goes through a plain 32-bit register port with byte offsets. Writes are strobed and reads are combinational.

Top module: `mpirq_ctrl`

## Requirements
- R1: Register byte offsets on `reg_addr`:
  - 0x04 is the shared pending register (read only).
  - 0x08 is an alias of processor 0's force register.
  - 0x0C is the clear register (write only).
  - 0x10 is status.
  - 0x14 is broadcast.
  - 0x40+4·n is the mask of processor n.
  - 0x80+4·n is the force register of processor n.
- R2: Bit i of every register stands for level i. Bit 0 is never stored. Force and broadcast writes keep bits 15:1. Mask writes keep only bits 14:1, so level 15 can never be enabled or signalled.
- R3: `cpu_level[4n+3:4n]` equals the index of the highest set bit of ((pending OR force[n]) AND mask[n]), or 0 when no such bit is set. It follows a register change in the cycle after the clock edge that made the change.
- R4: An `irq_in[L]` pulse with broadcast bit L set sets force bit L of every processor. With broadcast bit L clear, the pulse sets pending bit L.
- R5: An acknowledge of level L by processor n clears force[n] bit L if that bit is set. Otherwise it clears pending bit L.
- R6: Writing the clear register removes every pending bit written as 1 and leaves the others unchanged.
- R7: Reading status returns NCPU−1 in bits 31:28 and processor i's power-down flag in bit i. All other bits read as 0.
- R8: A `pwrdn_set[i]` strobe raises flag i. A status write with bit i at 1 clears flag i, and this clear wins over a set in the same cycle.
- R9: Reset clears pending, broadcast, all masks, all force registers and all power-down flags.
- R10: Reads of unmapped offsets and of the clear register return 0. Writes to unmapped offsets and to the pending register change no state.
- R11: An interrupt arrival on a level takes effect even when the same cycle carries an acknowledge, a clear or a register write that would remove that level.
- R12: An acknowledge with level 0, or with a processor index of NCPU or more, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | One-cycle interrupt pulses, bit L is level L, bit 0 unused |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | 2 | Index of the acknowledging processor |
| ack_level | input | 4 | Level being acknowledged |
| pwrdn_set | input | NCPU | Per-processor strobe raising the power-down flag |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cpu_level | output | 4*NCPU | Highest active enabled level per processor |

## Verification
The priority output is swept over a long series of computed force and mask words for every processor, on top of a fixed shared pending pattern. This separates errors in the OR, the AND and the encoder, because each word places its highest bit in a different spot.

Each level is pulsed once with a broadcast pattern that alternates across levels. This shows whether arrival routing chooses pending or force from the correct bit.

Paired acknowledges against a level that is both forced and pending confirm that the force bit is cleared first and the pending bit second. Arrivals that collide with acknowledges and clears show which side wins. Writes of all ones expose the masking of bit 0 and of level 15.

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl #(
  parameter int NCPU = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          irq_in,
  input  logic                 ack_valid,
  input  logic [1:0]           ack_cpu,
  input  logic [3:0]           ack_level,
  input  logic [NCPU-1:0]      pwrdn_set,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [4*NCPU-1:0]    cpu_level
);

  localparam logic [15:0] LVL_MASK = 16'hFFFE;
  localparam logic [15:0] ENA_MASK = 16'h7FFE;

  logic [15:0] pend, bcast;
  logic [15:0] mask  [NCPU];
  logic [15:0] force_r [NCPU];
  logic [NCPU-1:0] pwd;

  wire unused_wdata = ^reg_wdata[31:16];

  logic        wr_clr, wr_bc, wr_st;
  logic [NCPU-1:0] wr_mask, wr_force, ack_hit;
  logic [15:0] ack_bit, ack_fhit, irq_p, irq_f, wd16;

  assign wd16   = reg_wdata[15:0];
  assign wr_clr = reg_wr && reg_addr == 8'h0C;
  assign wr_bc  = reg_wr && reg_addr == 8'h14;
  assign wr_st  = reg_wr && reg_addr == 8'h10;
  assign irq_p  = irq_in & LVL_MASK & ~bcast;
  assign irq_f  = irq_in & LVL_MASK & bcast;
  assign ack_bit = (ack_valid && ack_level != 4'd0 && int'(ack_cpu) < NCPU)
                   ? (16'd1 << ack_level) : 16'd0;

  always_comb begin
    ack_fhit = '0;
    for (int n = 0; n < NCPU; n++) begin
      wr_mask[n]  = reg_wr && reg_addr == 8'(8'h40 + 4*n);
      wr_force[n] = reg_wr && (reg_addr == 8'(8'h80 + 4*n) || (n == 0 && reg_addr == 8'h08));
      ack_hit[n]  = ack_cpu == 2'(n);
      if (ack_hit[n]) ack_fhit = force_r[n] & ack_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      bcast <= '0;
      pwd   <= '0;
      for (int n = 0; n < NCPU; n++) begin
        mask[n]    <= '0;
        force_r[n] <= '0;
      end
    end else begin
      pend <= ((pend & ~(wr_clr ? wd16 : 16'd0) & ~(ack_bit & ~ack_fhit)) | irq_p) & LVL_MASK;
      if (wr_bc) bcast <= wd16 & LVL_MASK;
      pwd <= (pwd | pwrdn_set) & ~(wr_st ? reg_wdata[NCPU-1:0] : '0);
      for (int n = 0; n < NCPU; n++) begin
        if (wr_mask[n]) mask[n] <= wd16 & ENA_MASK;
        force_r[n] <= ((wr_force[n] ? wd16 : (force_r[n] & ~(ack_hit[n] ? ack_bit : 16'd0)))
                      | irq_f) & LVL_MASK;
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NCPU; n++) begin
      logic [15:0] act;
      act = (pend | force_r[n]) & mask[n] & LVL_MASK;
      cpu_level[4*n +: 4] = 4'd0;
      for (int l = 1; l < 16; l++)
        if (act[l]) cpu_level[4*n +: 4] = 4'(l);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h04: reg_rdata = {16'd0, pend};
      8'h08: reg_rdata = {16'd0, force_r[0]};
      8'h10: begin
        reg_rdata[31:28] = 4'(NCPU - 1);
        reg_rdata[NCPU-1:0] = pwd;
      end
      8'h14: reg_rdata = {16'd0, bcast};
      default: begin
        for (int n = 0; n < NCPU; n++) begin
          if (reg_addr == 8'(8'h40 + 4*n)) reg_rdata = {16'd0, mask[n]};
          if (reg_addr == 8'(8'h80 + 4*n)) reg_rdata = {16'd0, force_r[n]};
        end
      end
    endcase
  end

  AST_STATUS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 8'h10 |-> reg_rdata[31:28] == 4'(NCPU - 1)); // R7

  for (genvar n = 0; n < NCPU; n++) begin : g_chk
    AST_LVL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_level[4*n +: 4] != 4'd0 |-> mask[n][cpu_level[4*n +: 4]]); // R3
    AST_LVL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_level[4*n +: 4] != 4'd0 |-> (pend[cpu_level[4*n +: 4]] || force_r[n][cpu_level[4*n +: 4]])); // R3
    for (genvar l = 1; l < 16; l++) begin : g_lvl
      AST_BCAST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in[l] && bcast[l] |=> force_r[n][l]); // R4
      AST_ACK_FORCE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && ack_level == 4'(l) && ack_cpu == 2'(n) && force_r[n][l]
        && !irq_in[l] && !wr_force[n] |=> !force_r[n][l] && pend[l] == $past(pend[l]) || $past(wr_clr)); // R5
    end
  end

  for (genvar l = 1; l < 16; l++) begin : g_pend
    AST_ARRIVAL_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_in[l] && !bcast[l] |=> pend[l]); // R11
  end

endmodule

// File: tb/sim_mpirq_ctrl.sv
module sim_mpirq_ctrl;
  localparam int CLK_P = 10;
  localparam int NC = 4;

  logic clk = 0, rst_n = 0;
  logic [15:0] irq_in = '0;
  logic ack_valid = 0;
  logic [1:0] ack_cpu = '0;
  logic [3:0] ack_level = '0;
  logic [NC-1:0] pwrdn_set = '0;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4*NC-1:0] cpu_level;

  int checks = 0, errors = 0;
  logic [15:0] m_pend, m_bc;
  logic [15:0] m_mask [NC];
  logic [15:0] m_force [NC];
  logic [NC-1:0] m_pwd;

  always #(CLK_P/2) clk = ~clk;

  mpirq_ctrl #(.NCPU(NC)) u0 (.*);

  task automatic ck(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lvl(int n);
    logic [15:0] a;
    logic [3:0] r;
    a = (m_pend | m_force[n]) & m_mask[n] & 16'hFFFE;
    r = 0;
    for (int l = 1; l < 16; l++) if (a[l]) r = 4'(l);
    return r;
  endfunction

  task automatic rd_ck(string r, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    ck(r, reg_rdata, exp);
  endtask

  task automatic check_all(string r);
    rd_ck(r, 8'h04, {16'd0, m_pend});
    rd_ck(r, 8'h14, {16'd0, m_bc});
    for (int n = 0; n < NC; n++) begin
      ck(r, {28'd0, cpu_level[4*n +: 4]}, {28'd0, exp_lvl(n)});
      rd_ck(r, 8'(8'h40 + 4*n), {16'd0, m_mask[n]});
      rd_ck(r, 8'(8'h80 + 4*n), {16'd0, m_force[n]});
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    case (a)
      8'h08: m_force[0] = d[15:0] & 16'hFFFE;
      8'h0C: m_pend = m_pend & ~d[15:0];
      8'h10: m_pwd = m_pwd & ~d[NC-1:0];
      8'h14: m_bc = d[15:0] & 16'hFFFE;
      default:
        for (int n = 0; n < NC; n++) begin
          if (a == 8'(8'h40 + 4*n)) m_mask[n] = d[15:0] & 16'h7FFE;
          if (a == 8'(8'h80 + 4*n)) m_force[n] = d[15:0] & 16'hFFFE;
        end
    endcase
  endtask

  task automatic pulse_irq(logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    irq_in = '0;
    for (int l = 1; l < 16; l++)
      if (v[l]) begin
        if (m_bc[l]) for (int n = 0; n < NC; n++) m_force[n][l] = 1'b1;
        else m_pend[l] = 1'b1;
      end
  endtask

  task automatic ack(int c, int l);
    @(negedge clk);
    ack_valid = 1; ack_cpu = 2'(c); ack_level = 4'(l);
    @(negedge clk);
    ack_valid = 0;
    if (l != 0) begin
      if (m_force[c][l]) m_force[c][l] = 1'b0;
      else m_pend[l] = 1'b0;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_pend = 0; m_bc = 0; m_pwd = 0;
    for (int n = 0; n < NC; n++) begin m_mask[n] = 0; m_force[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R9");
    rd_ck("R9", 8'h10, 32'h3000_0000);

    // R2 masking of written values
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h84, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    check_all("R2");
    wr(8'h84, 0); wr(8'h14, 0);
    pulse_irq(16'h8000);
    check_all("R2");
    ck("R2", {28'd0, cpu_level[3:0]}, 32'd0);
    wr(8'h0C, 32'hFFFF);
    check_all("R6");

    // R1 alias of cpu0 force
    wr(8'h08, 32'h0000_0120);
    rd_ck("R1", 8'h80, 32'h0000_0120);
    wr(8'h80, 0);

    // R3 sweep
    pulse_irq(16'h0204);
    for (int k = 0; k < 48; k++) begin
      for (int n = 0; n < NC; n++) begin
        wr(8'(8'h80 + 4*n), 32'((k * 16'h9E37 + n * 16'h1111) ^ (k << 5)));
        wr(8'(8'h40 + 4*n), 32'((k * 16'h3B1D) ^ (n << 9) ^ 16'h5A5A));
      end
      check_all("R3");
    end
    for (int n = 0; n < NC; n++) begin wr(8'(8'h80 + 4*n), 0); wr(8'(8'h40 + 4*n), 32'hFFFF); end
    wr(8'h0C, 32'hFFFF);

    // R4 arrival routing with alternating broadcast
    wr(8'h14, 32'hAAAA);
    for (int l = 1; l < 16; l++) begin
      pulse_irq(16'(1 << l));
      check_all("R4");
    end

    // R5 acknowledge ordering
    for (int n = 0; n < NC; n++) wr(8'(8'h80 + 4*n), 0);
    wr(8'h14, 0);
    wr(8'h0C, 32'hFFFF);
    pulse_irq(16'h0020);
    wr(8'h84, 32'h0020);
    ack(1, 5);
    check_all("R5");
    ack(1, 5);
    check_all("R5");

    // R12 invalid acknowledge
    pulse_irq(16'h0040);
    ack(2, 0);
    check_all("R12");

    // R11 arrival beats acknowledge and clear
    @(negedge clk);
    irq_in = 16'h0040; ack_valid = 1; ack_cpu = 0; ack_level = 6;
    @(negedge clk);
    irq_in = 0; ack_valid = 0;
    check_all("R11");
    @(negedge clk);
    irq_in = 16'h0040; reg_addr = 8'h0C; reg_wdata = 32'h0040; reg_wr = 1;
    @(negedge clk);
    irq_in = 0; reg_wr = 0;
    check_all("R11");

    // R10 unmapped and read-only offsets
    wr(8'h04, 32'hFFFF);
    wr(8'h3C, 32'hFFFF);
    check_all("R10");
    rd_ck("R10", 8'h0C, 32'd0);
    rd_ck("R10", 8'h90, 32'd0);
    rd_ck("R10", 8'h20, 32'd0);

    // R7 / R8 power-down flags
    @(negedge clk); pwrdn_set = 4'b1011;
    @(negedge clk); pwrdn_set = 0; m_pwd = 4'b1011;
    rd_ck("R7", 8'h10, 32'h3000_000B);
    wr(8'h10, 32'h0000_0003);
    rd_ck("R8", 8'h10, 32'h3000_0008);
    @(negedge clk);
    pwrdn_set = 4'b0100; reg_addr = 8'h10; reg_wdata = 32'h4; reg_wr = 1;
    @(negedge clk);
    pwrdn_set = 0; reg_wr = 0;
    rd_ck("R8", 8'h10, 32'h3000_0008);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule